// File: doc/BRIEF.md
# Paged Register Address Decoder

This block sits between a small microcontroller core and its peripheral registers. It turns a direct-mode data access into a register select. Only the upper half of the 8-bit direct data space is register space. Each address there can stand for several registers, and a separate 8-bit page value picks among them. The block compares the address and the current page against a compile-time register table. It drives a one-hot select, or it flags the access as reserved when nothing lives at that address on that page.

Registers whose address has zero in its low three bits can also be reached one bit at a time. A bit access reads a single bit, or sets or clears one bit without disturbing the other seven. A bit access at any other address counts as reserved. The block holds a handful of demonstration registers so that the decode can be observed from outside. The page-select register is reachable on every page, so software can always switch pages. Its value is the page input itself.

Top module: `paged_reg_decoder`

## Requirements
- R1: An access whose address is below 0x80 selects nothing, does not raise `rsv_hit`, and reads 0x00.
- R2: `reg_sel` is one-hot or zero. Its bits map to (address, page) as follows: bit0 = 0x84 on any page, bit1 = 0x88/page 0x00, bit2 = 0x8A/page 0x00, bit3 = 0x88/page 0x01, bit4 = 0x90/page 0x02, bit5 = 0xC0/page 0x03, bit6 = 0xF8/page 0x0F, bit7 = 0x80/page 0x0F.
- R3: The same address on two different pages selects two separate registers with separate contents.
- R4: An access to 0x80..0xFF that matches no table entry raises `rsv_hit` in the same cycle, selects nothing and reads 0x00. This includes any address on a page outside {0x00, 0x01, 0x02, 0x03, 0x0F}.
- R5: The page-select register at 0x84 is selected on every page value, and a byte read of it returns `cur_page`.
- R6: A write to a reserved location changes no register.
- R7: A byte write stores `wdata` in the selected register at the rising clock edge. A byte read returns the selected register combinationally.
- R8: A bit write (`bit_mode`=1) replaces bit `bit_sel` of the register with `wdata[0]`. The other seven bits stay unchanged.
- R9: A bit access at an address whose low three bits are not zero is reserved and writes nothing.
- R10: A bit read returns the addressed bit in `rdata[0]`, with `rdata[7:1]` = 0.
- R11: Reset clears every stored register to 0x00.
- R12: With neither strobe high, `reg_sel` is zero and `rsv_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| bit_mode | input | 1 | Access targets a single bit |
| bit_sel | input | 3 | Bit index for bit accesses |
| dir_addr | input | 8 | Direct address |
| wdata | input | 8 | Write data; bit 0 is the bit value in bit mode |
| cur_page | input | 8 | Current page value |
| reg_sel | output | 8 | One-hot register select |
| rsv_hit | output | 1 | Access to a reserved location |
| rdata | output | 8 | Read data |

## Verification
The bench builds the block with its default 8-bit data width and the default eight-entry register table. This puts one shared address, 0x88, on two pages, and puts an unpopulated page and an empty slot on a populated page within reach. A table of decode vectors runs against the reset state and covers every select bit, the reserved cases and the lower half of the space. Directed sequences then cover byte writes, bit set and clear, bit reads, misaligned bit accesses, and writes that must be dropped.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
  localparam int DATA_W      = 8;
  localparam int BIT_IDX_W   = $clog2(DATA_W);
  localparam int NUM_REGS    = 8;
  localparam int PAGE_REG_IX = 0;
  localparam logic [7:0] PAGE_REG_ADDR = 8'h84;

  // Direct address of table entry i
  function automatic logic [7:0] reg_addr(int i);
    case (i)
      0: return PAGE_REG_ADDR;
      1: return 8'h88;
      2: return 8'h8A;
      3: return 8'h88;
      4: return 8'h90;
      5: return 8'hC0;
      6: return 8'hF8;
      7: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  // Page on which table entry i lives
  function automatic logic [7:0] reg_page(int i);
    case (i)
      1, 2: return 8'h00;
      3: return 8'h01;
      4: return 8'h02;
      5: return 8'h03;
      6, 7: return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic is_global(int i);
    return i == PAGE_REG_IX;
  endfunction

  function automatic logic page_populated(logic [7:0] p);
    return (p == 8'h00) || (p == 8'h01) || (p == 8'h02) ||
           (p == 8'h03) || (p == 8'h0F);
  endfunction

  function automatic logic bit_capable(logic [7:0] a);
    return a[2:0] == 3'b000;
  endfunction

  function automatic logic [DATA_W-1:0] bit_merge(logic [DATA_W-1:0] old,
                                                  logic [BIT_IDX_W-1:0] idx,
                                                  logic v);
    logic [DATA_W-1:0] r;
    r = old;
    r[idx] = v;
    return r;
  endfunction
endpackage

// File: rtl/pgd_decode.sv
module pgd_decode
  import pgd_pkg::*;
(
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic                bit_i,
  input  logic [7:0]          addr_i,
  input  logic [7:0]          page_i,
  output logic [NUM_REGS-1:0] sel_o,
  output logic                rsv_o
);
  logic                access;
  logic                in_range;
  logic                page_ok;
  logic                bit_bad;
  logic                grant;
  logic [NUM_REGS-1:0] raw_hit;

  assign access   = rd_i | wr_i;
  assign in_range = addr_i[7];
  assign page_ok  = page_populated(page_i);
  assign bit_bad  = bit_i & ~bit_capable(addr_i);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    localparam logic [7:0] ENT_ADDR = reg_addr(g);
    localparam logic [7:0] ENT_PAGE = reg_page(g);
    localparam logic       ENT_GLOB = is_global(g);
    if (ENT_GLOB) begin : g_glob
      assign raw_hit[g] = (addr_i == ENT_ADDR);
    end else begin : g_paged
      assign raw_hit[g] = (addr_i == ENT_ADDR) && page_ok && (page_i == ENT_PAGE);
    end
  end

  assign grant = access & in_range & ~bit_bad;
  assign sel_o = grant ? raw_hit : '0;
  assign rsv_o = access & in_range & (bit_bad | (raw_hit == '0));
endmodule

// File: rtl/pgd_bank.sv
module pgd_bank
  import pgd_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_REGS-1:1]                we_i,
  input  logic                               bit_i,
  input  logic [BIT_IDX_W-1:0]               bit_idx_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  input  logic [7:0]                         cur_page_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    val_o
);
  logic [NUM_REGS-1:1][DATA_W-1:0] store_q;

  assign val_o[0] = cur_page_i;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        store_q[g] <= '0;
      else if (we_i[g])
        store_q[g] <= bit_i ? bit_merge(store_q[g], bit_idx_i, wdata_i[0]) : wdata_i;
    end
    assign val_o[g] = store_q[g];

    AST_BIT_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i[g] && bit_i) |=>
        (((store_q[g] ^ $past(store_q[g])) & ~(DATA_W'(1) << $past(bit_idx_i))) == '0)); // R8
  end

  AST_HOLD_WITHOUT_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i == '0) |=> $stable(store_q)); // R6
endmodule

// File: rtl/paged_reg_decoder.sv
module paged_reg_decoder
  import pgd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic        bit_mode,
  input  logic [2:0]  bit_sel,
  input  logic [7:0]  dir_addr,
  input  logic [7:0]  wdata,
  input  logic [7:0]  cur_page,
  output logic [7:0]  reg_sel,
  output logic        rsv_hit,
  output logic [7:0]  rdata
);
  logic [NUM_REGS-1:0]             sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] vals;
  logic [NUM_REGS-1:1]             we_vec;
  logic [DATA_W-1:0]               byte_val;
  logic                            access;

  assign access = rd_en | wr_en;

  pgd_decode i_dec (
    .rd_i   (rd_en),
    .wr_i   (wr_en),
    .bit_i  (bit_mode),
    .addr_i (dir_addr),
    .page_i (cur_page),
    .sel_o  (sel),
    .rsv_o  (rsv_hit)
  );

  assign we_vec = wr_en ? sel[NUM_REGS-1:1] : '0;

  pgd_bank i_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (we_vec),
    .bit_i      (bit_mode),
    .bit_idx_i  (bit_sel),
    .wdata_i    (wdata),
    .cur_page_i (cur_page),
    .val_o      (vals)
  );

  always_comb begin
    byte_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel[i]) byte_val |= vals[i];
  end

  assign reg_sel = sel;
  assign rdata   = bit_mode ? {{(DATA_W-1){1'b0}}, byte_val[bit_sel]} : byte_val;

  AST_LOW_HALF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_addr[7] |-> (reg_sel == '0 && !rsv_hit)); // R1
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_sel)); // R2
  AST_RSV_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_hit |-> (reg_sel == '0 && rdata == '0)); // R4
  AST_PAGE_REG_ANY_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !bit_mode && dir_addr == PAGE_REG_ADDR) |-> (reg_sel[PAGE_REG_IX] && rdata == cur_page)); // R5
  AST_MISALIGNED_BIT_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (access && bit_mode && dir_addr[7] && dir_addr[2:0] != 3'b000) |-> (rsv_hit && reg_sel == '0)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !access |-> (reg_sel == '0 && !rsv_hit)); // R12
endmodule

// File: tb/test_paged_reg_decoder.sv
module test_paged_reg_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0, bit_mode = 1'b0;
  logic [2:0] bit_sel = '0;
  logic [7:0] dir_addr = '0, wdata = '0, cur_page = '0;
  logic [7:0] reg_sel, rdata;
  logic       rsv_hit;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_reg_decoder i_paged_reg_decoder (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .bit_mode(bit_mode), .bit_sel(bit_sel), .dir_addr(dir_addr),
    .wdata(wdata), .cur_page(cur_page), .reg_sel(reg_sel),
    .rsv_hit(rsv_hit), .rdata(rdata)
  );

  typedef struct packed {
    logic       rd;
    logic       bm;
    logic [2:0] idx;
    logic [7:0] addr;
    logic [7:0] page;
    logic [7:0] e_sel;
    logic       e_rsv;
    logic [7:0] e_data;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 3'd0, 8'h40, 8'h00, 8'h00, 1'b0, 8'h00},  // R1
    '{1'b1, 1'b0, 3'd0, 8'h7F, 8'h01, 8'h00, 1'b0, 8'h00},  // R1
    '{1'b1, 1'b0, 3'd0, 8'h88, 8'h00, 8'h02, 1'b0, 8'h00},  // R2
    '{1'b1, 1'b0, 3'd0, 8'h8A, 8'h00, 8'h04, 1'b0, 8'h00},  // R2
    '{1'b1, 1'b0, 3'd0, 8'h88, 8'h01, 8'h08, 1'b0, 8'h00},  // R3
    '{1'b1, 1'b0, 3'd0, 8'h90, 8'h02, 8'h10, 1'b0, 8'h00},  // R2
    '{1'b1, 1'b0, 3'd0, 8'hC0, 8'h03, 8'h20, 1'b0, 8'h00},  // R2
    '{1'b1, 1'b0, 3'd0, 8'hF8, 8'h0F, 8'h40, 1'b0, 8'h00},  // R2
    '{1'b1, 1'b0, 3'd0, 8'h80, 8'h0F, 8'h80, 1'b0, 8'h00},  // R2
    '{1'b1, 1'b0, 3'd0, 8'h88, 8'h05, 8'h00, 1'b1, 8'h00},  // R4
    '{1'b1, 1'b0, 3'd0, 8'h88, 8'h02, 8'h00, 1'b1, 8'h00},  // R4
    '{1'b1, 1'b0, 3'd0, 8'h84, 8'h7E, 8'h01, 1'b0, 8'h7E},  // R5
    '{1'b1, 1'b0, 3'd0, 8'h84, 8'h03, 8'h01, 1'b0, 8'h03},  // R5
    '{1'b1, 1'b1, 3'd1, 8'h8A, 8'h00, 8'h00, 1'b1, 8'h00},  // R9
    '{1'b1, 1'b1, 3'd2, 8'h84, 8'h00, 8'h00, 1'b1, 8'h00},  // R9
    '{1'b0, 1'b0, 3'd0, 8'h88, 8'h00, 8'h00, 1'b0, 8'h00},  // R12
    '{1'b1, 1'b0, 3'd0, 8'hFF, 8'h0F, 8'h00, 1'b1, 8'h00}   // R4
  };

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Drive one access at the falling edge; outputs are sampled 1 time unit later
  task automatic drive(input logic r, input logic w, input logic b, input logic [2:0] ix,
                       input logic [7:0] a, input logic [7:0] p, input logic [7:0] d);
    @(negedge clk);
    rd_en = r; wr_en = w; bit_mode = b; bit_sel = ix;
    dir_addr = a; cur_page = p; wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; bit_mode = 1'b0;
    #1;
  endtask

  task automatic rd_byte(input string req, input logic [7:0] a, input logic [7:0] p, input logic [7:0] exp);
    drive(1'b1, 1'b0, 1'b0, 3'd0, a, p, 8'h00);
    chk(req, "read data", {8'h0, rdata}, {8'h0, exp});
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] p, input logic [7:0] d);
    drive(1'b0, 1'b1, 1'b0, 3'd0, a, p, d);
    @(posedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Reset state: idle outputs quiet (R12), stored registers clear (R11)
    idle();
    chk("R12", "idle select", {8'h0, reg_sel}, 16'h0);
    chk("R12", "idle reserved", {15'h0, rsv_hit}, 16'h0);
    rd_byte("R11", 8'h88, 8'h00, 8'h00);
    rd_byte("R11", 8'hF8, 8'h0F, 8'h00);

    // Decode table against the reset contents
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].rd, 1'b0, VECS[i].bm, VECS[i].idx, VECS[i].addr, VECS[i].page, 8'h00);
      chk("R1/R2/R3/R4/R5/R9/R12 table", "select", {8'h0, reg_sel}, {8'h0, VECS[i].e_sel});
      chk("table", "reserved", {15'h0, rsv_hit}, {15'h0, VECS[i].e_rsv});
      chk("table", "read data", {8'h0, rdata}, {8'h0, VECS[i].e_data});
    end

    // R7: byte write lands at the clock edge, read combinational
    wr_byte(8'h88, 8'h00, 8'h5A);
    rd_byte("R7", 8'h88, 8'h00, 8'h5A);
    // R3: same address on page 1 is a separate register
    rd_byte("R3", 8'h88, 8'h01, 8'h00);
    wr_byte(8'h88, 8'h01, 8'hA5);
    rd_byte("R3", 8'h88, 8'h01, 8'hA5);
    rd_byte("R3", 8'h88, 8'h00, 8'h5A);

    // R6: write to reserved location is dropped
    drive(1'b0, 1'b1, 1'b0, 3'd0, 8'h88, 8'h05, 8'hFF);
    chk("R6", "reserved flag on write", {15'h0, rsv_hit}, 16'h1);
    @(posedge clk);
    rd_byte("R6", 8'h88, 8'h00, 8'h5A);
    rd_byte("R6", 8'h88, 8'h01, 8'hA5);
    drive(1'b0, 1'b1, 1'b0, 3'd0, 8'hA8, 8'h00, 8'hFF);
    @(posedge clk);
    rd_byte("R6", 8'h8A, 8'h00, 8'h00);

    // R8: bit set then bit clear
    drive(1'b0, 1'b1, 1'b1, 3'd0, 8'h88, 8'h00, 8'h01);
    @(posedge clk);
    rd_byte("R8", 8'h88, 8'h00, 8'h5B);
    drive(1'b0, 1'b1, 1'b1, 3'd6, 8'h88, 8'h00, 8'hFE);
    @(posedge clk);
    rd_byte("R8", 8'h88, 8'h00, 8'h1B);

    // R10: bit reads
    drive(1'b1, 1'b0, 1'b1, 3'd4, 8'h88, 8'h00, 8'h00);
    chk("R10", "bit 4 read", {8'h0, rdata}, 16'h0001);
    drive(1'b1, 1'b0, 1'b1, 3'd2, 8'h88, 8'h00, 8'h00);
    chk("R10", "bit 2 read", {8'h0, rdata}, 16'h0000);

    // R9: misaligned bit write is reserved and stores nothing
    drive(1'b0, 1'b1, 1'b1, 3'd3, 8'h8A, 8'h00, 8'h01);
    chk("R9", "reserved flag", {15'h0, rsv_hit}, 16'h1);
    chk("R9", "select", {8'h0, reg_sel}, 16'h0);
    @(posedge clk);
    rd_byte("R9", 8'h8A, 8'h00, 8'h00);
    rd_byte("R9", 8'h88, 8'h00, 8'h1B);

    // R7 on page 0x0F, neighbour untouched
    wr_byte(8'hF8, 8'h0F, 8'hC3);
    rd_byte("R7", 8'hF8, 8'h0F, 8'hC3);
    rd_byte("R7", 8'h80, 8'h0F, 8'h00);

    // R11: reset clears stored contents
    idle();
    rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    rd_byte("R11", 8'h88, 8'h00, 8'h00);
    rd_byte("R11", 8'hF8, 8'h0F, 8'h00);
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule